// File: doc/BRIEF.md
# Utilization-Driven Frequency Governor

This block chooses a processor performance level from how busy the processor has been. A single `busy_i` line is sampled on every clock edge. The block counts busy samples over a fixed evaluation window whose length is a parameter. When a window closes, the busy count is placed in one of three bands: high, low or middle. The performance-level index is then updated and sent to an external clock generator. Level index 0 is the fastest entry of a descending frequency table, and index NUM_LEVELS-1 is the slowest.

A small configuration register holds the policy and a user level. The policies are: automatic on-demand, fixed maximum, fixed minimum, and a fixed level chosen by the user. The on-demand policy is deliberately asymmetric. High load jumps straight to the top level. Low load lowers the frequency by about one fifth, one window at a time. A one-cycle strobe marks every cycle in which the level index changes.

Top module: `freq_governor`

## Requirements
- R1: After reset the mode is automatic (code 0), `level_o` is 0 (the fastest table entry) and `change_o` is 0.
- R2: The busy count is evaluated once every WIN_CYCLES clock edges. The first window starts with the first edge after reset release. The level stays constant for the whole window, and any resulting change is visible right after the first edge of the next window.
- R3: In automatic mode, a window whose busy count times 100 exceeds 80 times WIN_CYCLES sets the level to 0, from any level. With WIN_CYCLES=100 this means 81 or more busy samples.
- R4: In automatic mode, a window whose busy count times 100 is below 20 times WIN_CYCLES moves the level to the fastest table entry whose frequency is at most 80% of the current one. If no such entry exists, the level moves to the slowest entry. With the default table {2400000, 2133000, 1867000, 1600000} kHz, the moves are 0→2, 1→3, 2→3 and 3→3.
- R5: In automatic mode, a window whose count lies between those bands leaves the level unchanged. Both band edges are inclusive: 80 and 20 busy samples out of 100 are middle-band results.
- R6: Writing mode code 1 (`cfg_we_i` high for one edge) sets the level to 0 on the second edge counted from the write edge.
- R7: Writing mode code 2 sets the level to NUM_LEVELS-1 on the second edge counted from the write edge.
- R8: Writing mode code 3 together with `cfg_level_i` sets the level to the written value on the second edge counted from the write edge. A value beyond NUM_LEVELS-1 is clamped to NUM_LEVELS-1.
- R9: `change_o` is high for exactly the cycles in which `level_o` differs from its value in the previous cycle.
- R10: In modes 1, 2 and 3, window results have no effect on the level. After a switch back to mode 0, the level is kept until a window result changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Processor busy indication, sampled every edge |
| cfg_we_i | input | 1 | Write strobe for the mode and user-level register |
| cfg_mode_i | input | 2 | Policy: 0 automatic, 1 maximum, 2 minimum, 3 user |
| cfg_level_i | input | LVL_W | User level stored with the mode |
| level_o | output | LVL_W | Current performance-level index (0 = fastest) |
| change_o | output | 1 | One-cycle strobe when the level index changes |

## Verification
The automatic policy is driven with windows of chosen busy counts. Counts such as 0, 10, 19, 50, 81 and 100 separate the three bands. Counts of exactly 80 and 20 confirm that both band edges fall in the middle band. A run of low windows from the top level walks the step-down table through 0→2→3 and then holds at the bottom. Entering level 1 through user mode and then applying a low window exercises the 1→3 move. Windows whose busy count would raise or lower the level are applied while a fixed mode is active, which shows that window results are ignored there. Each window is also checked just before it closes, so a change that comes too early or a strobe that lasts too long is caught.

// File: rtl/gov_pkg.sv
`timescale 1ns/1ps
package gov_pkg;

   typedef enum logic [1:0] {
      MODE_AUTO = 2'd0,
      MODE_PERF = 2'd1,
      MODE_SAVE = 2'd2,
      MODE_USER = 2'd3
   } gov_mode_e;

   typedef enum logic [1:0] {
      UTIL_MID  = 2'd0,
      UTIL_HIGH = 2'd1,
      UTIL_LOW  = 2'd2
   } util_class_e;

endpackage

// File: rtl/gov_window.sv
`timescale 1ns/1ps
// Busy-sample accumulator: classifies each closed window without a divider.
module gov_window
   import gov_pkg::*;
#(
   parameter int WIN_CYCLES = 100,
   parameter int HI_PCT     = 80,
   parameter int LO_PCT     = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        busy_i,
   output logic        valid_o,
   output util_class_e class_o
);

   localparam int CNT_W  = $clog2(WIN_CYCLES + 1);
   // high when count*100 > HI_PCT*WIN  <=> count > floor(HI_PCT*WIN/100)
   localparam int HI_CNT = (HI_PCT * WIN_CYCLES) / 100;
   // low when count*100 < LO_PCT*WIN   <=> count < ceil(LO_PCT*WIN/100)
   localparam int LO_CNT = (LO_PCT * WIN_CYCLES + 99) / 100;

   logic [CNT_W-1:0] cyc_q;
   logic [CNT_W-1:0] busy_q;
   logic [CNT_W-1:0] total;
   logic             last;
   util_class_e      cls_d;

   assign last  = (cyc_q == CNT_W'(WIN_CYCLES - 1));
   assign total = busy_q + CNT_W'(busy_i);

   always_comb begin
      if (total > CNT_W'(HI_CNT))
         cls_d = UTIL_HIGH;
      else if (total < CNT_W'(LO_CNT))
         cls_d = UTIL_LOW;
      else
         cls_d = UTIL_MID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q   <= '0;
         busy_q  <= '0;
         valid_o <= 1'b0;
         class_o <= UTIL_MID;
      end else if (last) begin
         cyc_q   <= '0;
         busy_q  <= '0;
         valid_o <= 1'b1;
         class_o <= cls_d;
      end else begin
         cyc_q   <= cyc_q + CNT_W'(1);
         busy_q  <= total;
         valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/gov_step_table.sv
`timescale 1ns/1ps
// Step-down lookup: per level, the fastest entry not above (100-STEP_PCT)%.
module gov_step_table #(
   parameter int NUM_LEVELS = 4,
   parameter int FREQ_W     = 24,
   parameter logic [NUM_LEVELS-1:0][FREQ_W-1:0] FREQ_KHZ =
      {24'd1600000, 24'd1867000, 24'd2133000, 24'd2400000},
   parameter int STEP_PCT   = 20,
   localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
   input  logic [LVL_W-1:0] cur_i,
   output logic [LVL_W-1:0] tgt_o
);

   function automatic int find_target(int idx);
      longint lim;
      int     res;
      bit     found;
      lim   = longint'(FREQ_KHZ[idx]) * longint'(100 - STEP_PCT);
      res   = NUM_LEVELS - 1;
      found = 1'b0;
      for (int j = 0; j < NUM_LEVELS; j++) begin
         if (!found && (longint'(FREQ_KHZ[j]) * 100 <= lim)) begin
            res   = j;
            found = 1'b1;
         end
      end
      return res;
   endfunction

   logic [LVL_W-1:0] tgt_arr [NUM_LEVELS];

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      localparam int TGT = find_target(g);
      assign tgt_arr[g] = LVL_W'(TGT);
   end

   always_comb begin
      tgt_o = LVL_W'(NUM_LEVELS - 1);
      for (int k = 0; k < NUM_LEVELS; k++) begin
         if (cur_i == LVL_W'(k))
            tgt_o = tgt_arr[k];
      end
   end

endmodule

// File: rtl/gov_level_ctrl.sv
`timescale 1ns/1ps
// Policy register, level register and change strobe.
module gov_level_ctrl
   import gov_pkg::*;
#(
   parameter int NUM_LEVELS = 4,
   localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_i,
   input  logic [1:0]       cfg_mode_i,
   input  logic [LVL_W-1:0] cfg_level_i,
   input  logic             win_valid_i,
   input  util_class_e      win_class_i,
   input  logic [LVL_W-1:0] step_tgt_i,
   output gov_mode_e        mode_o,
   output logic [LVL_W-1:0] level_o,
   output logic             change_o
);

   localparam logic [LVL_W-1:0] LVL_MAX = '0;
   localparam logic [LVL_W-1:0] LVL_MIN = LVL_W'(NUM_LEVELS - 1);

   logic [LVL_W-1:0] user_q;
   logic [LVL_W-1:0] user_eff;
   logic [LVL_W-1:0] level_d;

   // clamp only needed when the index width can encode unused levels
   if ((1 << LVL_W) == NUM_LEVELS) begin : g_noclamp
      assign user_eff = user_q;
   end else begin : g_clamp
      assign user_eff = (user_q > LVL_MIN) ? LVL_MIN : user_q;
   end

   always_comb begin
      level_d = level_o;
      unique case (mode_o)
         MODE_PERF: level_d = LVL_MAX;
         MODE_SAVE: level_d = LVL_MIN;
         MODE_USER: level_d = user_eff;
         default: begin
            if (win_valid_i) begin
               if (win_class_i == UTIL_HIGH)
                  level_d = LVL_MAX;
               else if (win_class_i == UTIL_LOW)
                  level_d = step_tgt_i;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= MODE_AUTO;
         user_q <= LVL_MAX;
      end else if (cfg_we_i) begin
         mode_o <= gov_mode_e'(cfg_mode_i);
         user_q <= cfg_level_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o  <= LVL_MAX;
         change_o <= 1'b0;
      end else begin
         level_o  <= level_d;
         change_o <= (level_d != level_o);
      end
   end

endmodule

// File: rtl/freq_governor.sv
`timescale 1ns/1ps
module freq_governor
   import gov_pkg::*;
#(
   parameter int WIN_CYCLES = 100,
   parameter int NUM_LEVELS = 4,
   parameter int FREQ_W     = 24,
   parameter logic [NUM_LEVELS-1:0][FREQ_W-1:0] FREQ_KHZ =
      {24'd1600000, 24'd1867000, 24'd2133000, 24'd2400000},
   parameter int HI_PCT     = 80,
   parameter int LO_PCT     = 20,
   parameter int STEP_PCT   = 20,
   localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             cfg_we_i,
   input  logic [1:0]       cfg_mode_i,
   input  logic [LVL_W-1:0] cfg_level_i,
   output logic [LVL_W-1:0] level_o,
   output logic             change_o
);

   function automatic bit table_descending();
      bit ok;
      ok = 1'b1;
      for (int i = 1; i < NUM_LEVELS; i++)
         if (FREQ_KHZ[i] >= FREQ_KHZ[i-1]) ok = 1'b0;
      return ok;
   endfunction

   if (WIN_CYCLES < 5) begin : g_chk_win
      $error("freq_governor: WIN_CYCLES must be at least 5");
   end
   if (NUM_LEVELS < 2) begin : g_chk_lvl
      $error("freq_governor: NUM_LEVELS must be at least 2");
   end
   if (!(LO_PCT < HI_PCT && HI_PCT < 100 && LO_PCT > 0)) begin : g_chk_pct
      $error("freq_governor: need 0 < LO_PCT < HI_PCT < 100");
   end
   if (STEP_PCT <= 0 || STEP_PCT >= 100) begin : g_chk_step
      $error("freq_governor: STEP_PCT out of range");
   end
   if (!table_descending()) begin : g_chk_tbl
      $error("freq_governor: FREQ_KHZ must be strictly descending");
   end

   logic             win_valid;
   util_class_e      win_class;
   logic [LVL_W-1:0] step_tgt;
   gov_mode_e        mode_q;

   gov_window #(
      .WIN_CYCLES(WIN_CYCLES),
      .HI_PCT    (HI_PCT),
      .LO_PCT    (LO_PCT)
   ) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_i),
      .valid_o(win_valid),
      .class_o(win_class)
   );

   gov_step_table #(
      .NUM_LEVELS(NUM_LEVELS),
      .FREQ_W    (FREQ_W),
      .FREQ_KHZ  (FREQ_KHZ),
      .STEP_PCT  (STEP_PCT)
   ) u_step (
      .cur_i(level_o),
      .tgt_o(step_tgt)
   );

   gov_level_ctrl #(
      .NUM_LEVELS(NUM_LEVELS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we_i   (cfg_we_i),
      .cfg_mode_i (cfg_mode_i),
      .cfg_level_i(cfg_level_i),
      .win_valid_i(win_valid),
      .win_class_i(win_class),
      .step_tgt_i (step_tgt),
      .mode_o     (mode_q),
      .level_o    (level_o),
      .change_o   (change_o)
   );

endmodule

// File: rtl/gov_checker.sv
`timescale 1ns/1ps
module gov_checker
   import gov_pkg::*;
#(
   parameter int NUM_LEVELS = 4,
   parameter int LVL_W      = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] level_o,
   input logic             change_o,
   input gov_mode_e        mode_q,
   input logic             win_valid,
   input util_class_e      win_class
);

   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LVL_W'(NUM_LEVELS - 1)); // R8

   AST_HIGH_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_AUTO && win_valid && win_class == UTIL_HIGH) |=> (level_o == '0)); // R3

   AST_LOW_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_AUTO && win_valid && win_class == UTIL_LOW) |=> (level_o >= $past(level_o))); // R4

   AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_AUTO && win_valid && win_class == UTIL_MID) |=> $stable(level_o)); // R5

   AST_AUTO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_AUTO && !win_valid) |=> $stable(level_o)); // R2

   AST_PERF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PERF) |=> (level_o == '0)); // R6

   AST_SAVE_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SAVE) |=> (level_o == LVL_W'(NUM_LEVELS - 1))); // R7

   AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> change_o); // R9

   AST_STROBE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      change_o |-> (level_o != $past(level_o))); // R9

endmodule

bind freq_governor gov_checker #(
   .NUM_LEVELS(NUM_LEVELS),
   .LVL_W     (LVL_W)
) u_gov_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .level_o  (level_o),
   .change_o (change_o),
   .mode_q   (mode_q),
   .win_valid(win_valid),
   .win_class(win_class)
);

// File: tb/test_freq_governor.sv
`timescale 1ns/1ps
module test_freq_governor;

   localparam int WIN   = 100;
   localparam int LVL_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             busy_i = 1'b0;
   logic             cfg_we_i = 1'b0;
   logic [1:0]       cfg_mode_i = 2'd0;
   logic [LVL_W-1:0] cfg_level_i = '0;
   logic [LVL_W-1:0] level_o;
   logic             change_o;

   always #2.5 clk = ~clk;

   freq_governor #(.WIN_CYCLES(WIN)) i_freq_governor (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_i),
      .cfg_we_i   (cfg_we_i),
      .cfg_mode_i (cfg_mode_i),
      .cfg_level_i(cfg_level_i),
      .level_o    (level_o),
      .change_o   (change_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // expected state tracked by the bench
   int pend_lvl = 0;   // level expected right after next window's first edge
   int pend_chg = 0;
   int cur_lvl  = 0;
   bit cfg_pend = 1'b0;
   int cfg_m    = 0;
   int cfg_l    = 0;
   int cfg_exp  = 0;
   string cfg_tag = "";
   string pend_tag = "R1";

   // vectors: busy count in window, expected level after it (automatic mode)
   localparam int NVEC = 9;
   localparam int VEC [NVEC][2] = '{
      '{50, 0},   // R5 middle band holds top level
      '{10, 2},   // R4 0 -> 2
      '{19, 3},   // R4 2 -> 3
      '{0,  3},   // R4 bottom stays
      '{81, 0},   // R3 jump to top
      '{80, 0},   // R5 upper edge is middle
      '{20, 0},   // R5 lower edge is middle
      '{19, 2},   // R4 19 is low
      '{100, 0}   // R3 full busy
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic string band_tag(input int nb);
      if (nb * 100 > 80 * WIN) return "R3";
      if (nb * 100 < 20 * WIN) return "R4";
      return "R5";
   endfunction

   // one window of WIN edges; entered and left at a falling edge
   task automatic win(input int nb, input int exp_after, input string tag);
      for (int i = 0; i < WIN; i++) begin
         if (i == 0 && cfg_pend) begin
            cfg_we_i    = 1'b1;
            cfg_mode_i  = 2'(cfg_m);
            cfg_level_i = LVL_W'(cfg_l);
         end
         if (i == 1) begin
            cfg_we_i = 1'b0;
            chk({pend_tag, " level after window"}, int'(level_o), pend_lvl);
            chk({"R9 strobe after window (", pend_tag, ")"}, int'(change_o), pend_chg);
            cur_lvl = pend_lvl;
         end
         if (i == 2) begin
            if (cfg_pend) begin
               chk({cfg_tag, " level after mode write"}, int'(level_o), cfg_exp);
               chk({"R9 strobe after mode write (", cfg_tag, ")"}, int'(change_o),
                   (cfg_exp != cur_lvl) ? 1 : 0);
               cur_lvl  = cfg_exp;
               cfg_pend = 1'b0;
            end else begin
               chk("R9 strobe lasts one cycle", int'(change_o), 0);
            end
         end
         if (i == WIN - 1) begin
            chk("R2 level steady inside window", int'(level_o), cur_lvl);
            chk("R2 no strobe inside window", int'(change_o), 0);
         end
         busy_i = (i < nb);
         @(negedge clk);
      end
      pend_chg = (exp_after != cur_lvl) ? 1 : 0;
      pend_lvl = exp_after;
      pend_tag = tag;
   endtask

   task automatic set_cfg(input int m, input int l, input int exp, input string tag);
      cfg_pend = 1'b1;
      cfg_m    = m;
      cfg_l    = l;
      cfg_exp  = exp;
      cfg_tag  = tag;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset level", int'(level_o), 0);
      chk("R1 reset strobe", int'(change_o), 0);
      rst_n = 1'b1;

      // automatic-mode table walk (R1: automatic is the reset mode)
      for (int v = 0; v < NVEC; v++)
         win(VEC[v][0], VEC[v][1], band_tag(VEC[v][0]));

      // user level 1; a low window is ignored there (R10)
      set_cfg(3, 1, 1, "R8");
      win(5, 1, "R10 user mode ignores low window");
      // back to automatic: level kept, then low window 1 -> 3
      set_cfg(0, 0, 1, "R10 auto keeps level");
      win(10, 3, "R4 step 1 -> 3");
      // fixed maximum; low window ignored
      set_cfg(1, 0, 0, "R6");
      win(0, 0, "R10 max mode ignores low window");
      // fixed minimum; high window ignored
      set_cfg(2, 0, 3, "R7");
      win(100, 3, "R10 min mode ignores high window");
      // user level 2; high window ignored
      set_cfg(3, 2, 2, "R8");
      win(90, 2, "R10 user mode ignores high window");
      // automatic again: high window jumps from 2 to top
      set_cfg(0, 0, 2, "R10 auto keeps level");
      win(90, 0, "R3 jump from 2");
      win(50, 0, "R5");
      finish_run();
   end

endmodule